// File: doc/BRIEF.md
# Parallel Memory Bus Sequencer

This block drives the pins of an old-style parallel nonvolatile memory (UV-erasable ROM, electrically erasable ROM or simple flash) one byte at a time. A host places an address, write data and a read/write flag on a valid/ready command port. The sequencer then produces the active-low chip-enable, output-enable and write-enable strobes, an output enable for the data bus, and returns the byte that was read together with an error bit when the access completes.

Timing comes from configuration inputs given in clock cycles: read setup, write setup, write hold and an optional post-write wait for page-write devices that cannot be polled. Chip enable is formed from the two other strobes, so it rises and falls again around every access, which keeps devices working that latch the address on the falling chip-enable edge. With verification turned on, every written byte is read back and the write is repeated up to a configurable number of attempts. The configuration inputs are expected to stay constant while an access is in progress.

Top module: `pmem_seq`

## Requirements
- R1: `mem_ce_n` always equals `mem_oe_n` AND `mem_we_n`; output enable and write enable are never low together.
- R2: Each access is accepted only while chip enable is high, the address changes only while chip enable is high, and every access produces exactly one falling chip-enable edge per strobe pulse, so a device that latches the address on that edge returns the byte at the requested address.
- R3: A read holds `mem_oe_n` low for `cfg_rd_setup`+1 cycles, samples `mem_din` on the edge where it rises, and reports that byte with `done` exactly `cfg_rd_setup`+2 clock edges after the accepting edge.
- R4: A write holds `mem_we_n` low for `cfg_wr_setup`+1 cycles while `mem_dout_en` is 1 and `mem_dout` equals the requested byte.
- R5: After `mem_we_n` rises, the sequencer waits H+1 cycles before anything else, where H is `cfg_wr_hold`, or `cfg_rd_setup` when `cfg_wr_hold` is 0.
- R6: When `cfg_post_wait` P is nonzero, a further P+1 cycles follow the hold of R5; when P is 0 no cycle is added.
- R7: With `cfg_verify`=1 every write attempt is followed by a read of the same address; on a match the access ends with `done_err`=0, otherwise the write is retried until T attempts were made (T = `cfg_tries`, with 0 meaning 1), after which it ends with `done_err`=1. `done_rdata` is the last byte read back. A write without verification returns `done_rdata`=0 and `done_err`=0.
- R8: `mem_dout_en` is 0 in every cycle in which `mem_oe_n` is 0, and 0 after reset.
- R9: `req_ready` is 1 only when idle and goes 0 on the cycle after a request is accepted until the access completes; `done` is a single-cycle pulse, and a new request may be accepted in the cycle that `done` is high.
- R10: After reset all three strobes are 1, `mem_dout_en` is 0, `req_ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_setup | input | CW | Read setup cycles |
| cfg_wr_setup | input | CW | Write setup cycles |
| cfg_wr_hold | input | CW | Write hold cycles, 0 selects read setup |
| cfg_post_wait | input | PW | Extra wait after a write, 0 disables |
| cfg_verify | input | 1 | Read back and retry each write |
| cfg_tries | input | TRY_W | Maximum write attempts, 0 means 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DW | Read or read-back byte, valid with done |
| done_err | output | 1 | Verification failed, valid with done |
| mem_addr | output | AW | Device address pins |
| mem_dout | output | DW | Data driven toward the device |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DW | Data from the device |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The completion of one access and the acceptance of the next can fall in the same cycle: the bench issues its next request at the very sampling point where it sees `done`, so the new address is taken while the `done` pulse is still high. It judges this collision through a device model that latches the address only on a falling chip-enable edge; if chip enable failed to return high between the two accesses, the read would return the previous location's byte, and the model's result is compared with a shadow copy of memory kept by the bench. Strobe widths, chip-enable fall counts and total latency of each back-to-back access are checked against formulas in the bench.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
  parameter int TRY_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACT,
    ST_HOLD,
    ST_POST
  } seq_state_t;

  // Attempts allowed for one verified write; a zero setting still writes once.
  function automatic logic [TRY_W-1:0] eff_tries(input logic [TRY_W-1:0] t);
    return (t == '0) ? TRY_W'(1) : t;
  endfunction
endpackage

// File: rtl/pmem_timer.sv
module pmem_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pmem_ctrl.sv
module pmem_ctrl
  import pmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int PW = 16,
  parameter int TW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_rd_setup,
  input  logic [CW-1:0]    cfg_wr_setup,
  input  logic [CW-1:0]    cfg_wr_hold,
  input  logic [PW-1:0]    cfg_post_wait,
  input  logic             cfg_verify,
  input  logic [TRY_W-1:0] cfg_tries,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             done,
  output logic [DW-1:0]    done_rdata,
  output logic             done_err,
  output logic [AW-1:0]    addr_out,
  output logic [DW-1:0]    wdata_out,
  input  logic [DW-1:0]    mem_din,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  input  logic             tmr_zero,
  output logic             rd_low_d,
  output logic             wr_low_d,
  output logic             drv_d,
  output logic             ev_accept,
  output logic             ev_strobe_end
);
  // Hold after a write: zero setting falls back to the read setup value.
  function automatic logic [CW-1:0] hold_cycles(input logic [CW-1:0] h,
                                                input logic [CW-1:0] rs);
    return (h == '0) ? rs : h;
  endfunction

  // True when the attempt just finished was the last one allowed.
  function automatic logic out_of_tries(input logic [TRY_W-1:0] used,
                                        input logic [TRY_W-1:0] limit);
    return ({1'b0, used} + (TRY_W+1)'(1)) >= {1'b0, eff_tries(limit)};
  endfunction

  seq_state_t       st_q, st_d;
  logic             ph_wr_q, ph_wr_d;    // current phase drives WE
  logic             op_wr_q;             // request was a write
  logic [TRY_W-1:0] tries_q, tries_d;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic             done_q;
  logic             err_q;
  logic [DW-1:0]    rdata_q;
  logic             fin, fin_err, wr_finish;
  logic [DW-1:0]    fin_data;

  assign req_ready     = (st_q == ST_IDLE);
  assign ev_accept     = req_valid && req_ready;
  assign ev_strobe_end = (st_q == ST_ACT) && tmr_zero;

  always_comb begin
    st_d      = st_q;
    ph_wr_d   = ph_wr_q;
    tries_d   = tries_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    fin       = 1'b0;
    fin_err   = 1'b0;
    fin_data  = '0;
    wr_finish = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d    = ST_ADDR;
        ph_wr_d = req_write;
        tries_d = '0;
      end
      ST_ADDR: begin
        st_d     = ST_ACT;
        tmr_load = 1'b1;
        tmr_val  = ph_wr_q ? TW'(cfg_wr_setup) : TW'(cfg_rd_setup);
      end
      ST_ACT: if (tmr_zero) begin
        if (ph_wr_q) begin
          st_d     = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = TW'(hold_cycles(cfg_wr_hold, cfg_rd_setup));
        end else if (!op_wr_q || mem_din == wdata_q) begin
          fin      = 1'b1;
          fin_data = mem_din;
          st_d     = ST_IDLE;
        end else if (out_of_tries(tries_q, cfg_tries)) begin
          fin      = 1'b1;
          fin_err  = 1'b1;
          fin_data = mem_din;
          st_d     = ST_IDLE;
        end else begin
          tries_d = tries_q + 1'b1;
          ph_wr_d = 1'b1;
          st_d    = ST_ADDR;
        end
      end
      ST_HOLD: if (tmr_zero) begin
        if (cfg_post_wait != '0) begin
          st_d     = ST_POST;
          tmr_load = 1'b1;
          tmr_val  = TW'(cfg_post_wait);
        end else begin
          wr_finish = 1'b1;
        end
      end
      ST_POST: if (tmr_zero) wr_finish = 1'b1;
      default: st_d = ST_IDLE;
    endcase
    if (wr_finish) begin
      if (cfg_verify) begin
        ph_wr_d = 1'b0;
        st_d    = ST_ADDR;
      end else begin
        fin  = 1'b1;
        st_d = ST_IDLE;
      end
    end
  end

  // Strobe intentions for the next cycle, registered by the pin stage.
  assign rd_low_d = (st_d == ST_ACT) && !ph_wr_d;
  assign wr_low_d = (st_d == ST_ACT) && ph_wr_d;
  assign drv_d    = ph_wr_d && (st_d != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_wr_q <= 1'b0;
      op_wr_q <= 1'b0;
      tries_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      ph_wr_q <= ph_wr_d;
      tries_q <= tries_d;
      done_q  <= fin;
      err_q   <= fin && fin_err;
      if (fin) rdata_q <= fin_data;
      if (ev_accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        op_wr_q <= req_write;
      end
    end
  end

  assign done       = done_q;
  assign done_err   = err_q;
  assign done_rdata = rdata_q;
  assign addr_out   = addr_q;
  assign wdata_out  = wdata_q;
endmodule

// File: rtl/pmem_pins.sv
module pmem_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_low_d,
  input  logic wr_low_d,
  input  logic drv_d,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dout_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dout_en <= 1'b0;
    end else begin
      oe_n    <= !rd_low_d;
      we_n    <= !wr_low_d;
      ce_n    <= !(rd_low_d || wr_low_d);
      dout_en <= drv_d && !rd_low_d;
    end
  end
endmodule

// File: rtl/pmem_seq.sv
module pmem_seq
  import pmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int PW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_rd_setup,
  input  logic [CW-1:0]    cfg_wr_setup,
  input  logic [CW-1:0]    cfg_wr_hold,
  input  logic [PW-1:0]    cfg_post_wait,
  input  logic             cfg_verify,
  input  logic [TRY_W-1:0] cfg_tries,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             done,
  output logic [DW-1:0]    done_rdata,
  output logic             done_err,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_dout_en,
  input  logic [DW-1:0]    mem_din,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             mem_we_n
);
  localparam int TW = (CW > PW) ? CW : PW;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          rd_low_d, wr_low_d, drv_d;
  logic          ev_accept, ev_strobe_end;

  pmem_ctrl #(.AW(AW), .DW(DW), .CW(CW), .PW(PW), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_setup(cfg_rd_setup), .cfg_wr_setup(cfg_wr_setup),
    .cfg_wr_hold(cfg_wr_hold), .cfg_post_wait(cfg_post_wait),
    .cfg_verify(cfg_verify), .cfg_tries(cfg_tries),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .done_rdata(done_rdata), .done_err(done_err),
    .addr_out(mem_addr), .wdata_out(mem_dout), .mem_din(mem_din),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_zero(tmr_zero),
    .rd_low_d(rd_low_d), .wr_low_d(wr_low_d), .drv_d(drv_d),
    .ev_accept(ev_accept), .ev_strobe_end(ev_strobe_end)
  );

  pmem_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_zero)
  );

  pmem_pins u_pins (
    .clk(clk), .rst_n(rst_n), .rd_low_d(rd_low_d), .wr_low_d(wr_low_d),
    .drv_d(drv_d), .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .dout_en(mem_dout_en)
  );
endmodule

// File: rtl/pmem_seq_chk.sv
module pmem_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          done_err,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dout,
  input logic          mem_dout_en,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          ev_accept,
  input logic          ev_strobe_end
);
  p_ce_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n == (mem_oe_n && mem_we_n));

  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n || mem_we_n);

  p_addr_ce_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> mem_ce_n);

  p_accept_ce_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> mem_ce_n);

  p_strobe_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe_end |=> (mem_oe_n && mem_we_n));

  p_wdata_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dout) && mem_dout_en));

  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  p_no_fight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dout_en);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pmem_seq pmem_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .done_err(done_err), .mem_addr(mem_addr), .mem_dout(mem_dout),
  .mem_dout_en(mem_dout_en), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .ev_accept(ev_accept), .ev_strobe_end(ev_strobe_end)
);

// File: tb/pmem_seq_bench.sv
module pmem_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_rd_setup = '0, cfg_wr_setup = '0, cfg_wr_hold = '0;
  logic [15:0] cfg_post_wait = '0;
  logic        cfg_verify = 1'b0;
  logic [3:0]  cfg_tries = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done, done_err;
  logic [7:0]  done_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_dout, mem_din;
  logic        mem_dout_en, mem_ce_n, mem_oe_n, mem_we_n;

  int nchk = 0, nerr = 0;
  int we_rises = 0, drop_until = 0;
  logic [7:0] dev_mem [0:255];
  logic [7:0] shadow  [0:255];
  logic [7:0] lat = '0;

  always #4 clk = ~clk;

  pmem_seq u_pmem_seq (.*);

  // Device model: address captured on the falling chip-enable edge.
  always @(negedge mem_ce_n) lat <= mem_addr[7:0];
  always @(posedge mem_we_n) if (rst_n) begin
    if (we_rises >= drop_until) dev_mem[lat] <= mem_dout;
    we_rises <= we_rises + 1;
  end
  assign mem_din = (!mem_oe_n && !mem_ce_n) ? dev_mem[lat] : 8'h00;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 5);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [15:0] a, input logic [7:0] d,
                       input int drops);
    int cyc, oe_low, we_low, ce_falls, rdy_hi, r1_bad, r4_bad, r8_bad;
    int t_lim, att, rs, ws, h, p, n_wr, n_rd, n_exp;
    bit prev_ce, exp_err;
    logic [7:0] exp_d, got_d;
    bit got_e;
    while (!req_ready) @(negedge clk);
    drop_until = we_rises + drops;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; oe_low = 0; we_low = 0; ce_falls = 0; rdy_hi = 0;
    r1_bad = 0; r4_bad = 0; r8_bad = 0; prev_ce = 1'b1;
    while (!done && cyc < 20000) begin
      if (!mem_oe_n) oe_low++;
      if (!mem_we_n) begin
        we_low++;
        if (!mem_dout_en || mem_dout != d) r4_bad++;
      end
      if (prev_ce && !mem_ce_n) ce_falls++;
      prev_ce = mem_ce_n;
      if (req_ready) rdy_hi++;
      if (mem_ce_n != (mem_oe_n & mem_we_n)) r1_bad++;
      if (!mem_oe_n && mem_dout_en) r8_bad++;
      @(negedge clk);
      cyc++;
    end
    got_d = done_rdata; got_e = done_err;
    drop_until = we_rises;
    // expectation from the requirements
    rs = int'(cfg_rd_setup); ws = int'(cfg_wr_setup);
    h  = (cfg_wr_hold == 0) ? rs : int'(cfg_wr_hold);
    p  = int'(cfg_post_wait);
    t_lim = (cfg_tries == 0) ? 1 : int'(cfg_tries);
    n_rd = rs + 2;
    n_wr = 1 + (ws + 1) + (h + 1) + ((p != 0) ? p + 1 : 0);
    exp_err = 1'b0;
    if (!wr) begin
      att = 1; n_exp = n_rd; exp_d = shadow[a[7:0]];
    end else if (cfg_verify) begin
      att = (drops + 1 <= t_lim) ? drops + 1 : t_lim;
      exp_err = (drops >= t_lim);
      exp_d = exp_err ? shadow[a[7:0]] : d;
      n_exp = att * (n_wr + n_rd);
    end else begin
      att = 1; n_exp = n_wr; exp_d = 8'h00;
    end
    if (wr && !exp_err) shadow[a[7:0]] = d;
    chk(cyc == n_exp + 1, !wr ? "R3" : cfg_verify ? "R7" : (p != 0) ? "R6" : "R5",
        "latency", cyc, n_exp + 1);
    chk(got_d == exp_d, wr ? "R7" : "R3", "rdata", got_d, exp_d);
    chk(got_e == exp_err, "R7", "err", got_e, exp_err);
    chk(oe_low == ((!wr) ? rs + 1 : cfg_verify ? att * (rs + 1) : 0), "R3",
        "oe low cycles", oe_low, (!wr) ? rs + 1 : cfg_verify ? att * (rs + 1) : 0);
    chk(we_low == (wr ? att * (ws + 1) : 0), "R4", "we low cycles", we_low,
        wr ? att * (ws + 1) : 0);
    chk(ce_falls == ((!wr) ? 1 : cfg_verify ? 2 * att : 1), "R2", "ce falls",
        ce_falls, (!wr) ? 1 : cfg_verify ? 2 * att : 1);
    chk(r4_bad == 0, "R4", "data during we low", r4_bad, 0);
    chk(r1_bad == 0, "R1", "ce relation", r1_bad, 0);
    chk(r8_bad == 0, "R8", "bus fight", r8_bad, 0);
    chk(rdy_hi == 0, "R9", "ready while busy", rdy_hi, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = pat(i);
      shadow[i]  = pat(i);
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R10", "strobes in reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dout_en && !done, "R10", "dout_en/done in reset",
        {mem_dout_en, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);

    // directed: minimum read setup, back-to-back reads of neighbours (R2, R3)
    cfg_rd_setup = 0; cfg_wr_setup = 0;
    do_op(1'b0, 16'h0010, 8'h00, 0);
    do_op(1'b0, 16'h0011, 8'h00, 0);
    do_op(1'b0, 16'h0000, 8'h00, 0);
    // R5: zero hold falls back to read setup
    cfg_rd_setup = 5; cfg_wr_setup = 2; cfg_wr_hold = 0;
    do_op(1'b1, 16'h0020, 8'hA5, 0);
    do_op(1'b0, 16'h0020, 8'h00, 0);
    cfg_wr_hold = 1;
    do_op(1'b1, 16'h0021, 8'h3C, 0);
    // R6: post-write wait
    cfg_post_wait = 40;
    do_op(1'b1, 16'h0022, 8'h77, 0);
    cfg_post_wait = 0;
    // R7: verify with retries
    cfg_verify = 1; cfg_tries = 0;
    do_op(1'b1, 16'h0030, 8'h11, 1);
    cfg_tries = 3;
    do_op(1'b1, 16'h0031, 8'h22, 2);
    do_op(1'b1, 16'h0032, 8'h33, 3);
    do_op(1'b0, 16'h0032, 8'h00, 0);
    cfg_verify = 0;

    // constrained random mix
    for (int k = 0; k < 160; k++) begin
      bit w;
      int dr;
      if (($urandom % 4) == 0) begin
        cfg_rd_setup  = 8'($urandom % 6);
        cfg_wr_setup  = 8'($urandom % 6);
        cfg_wr_hold   = 8'($urandom % 4);
        cfg_post_wait = 16'((($urandom % 3) == 0) ? $urandom % 8 : 0);
        cfg_verify    = $urandom % 2;
        cfg_tries     = 4'($urandom % 5);
      end
      w  = $urandom % 2;
      dr = (w && cfg_verify) ? int'($urandom % 4) : 0;
      if (($urandom % 3) == 0) repeat ($urandom % 4) @(negedge clk);
      do_op(w, 16'($urandom), 8'($urandom), dr);
    end

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule